// File: doc/BRIEF.md
# BIST Clock-Cycle Counter

This block lets a parked local scan port run a built-in self-test for a fixed number of test clocks, and then stops the clock to that port. Software loads the required cycle count into a down counter with an ordinary data-register scan, while the counter is the selected data register. Separate on and off commands enable or disable counting. Completion is reported on a status output, which a neighbouring mode register exposes as its bit 7.

The counter decrements once per test-clock edge while it is on. It starts on the edge after the one that loaded it. It stops at zero and does not wrap. Zero is the terminal count. When the counter is on, at terminal count and the port is parked, the local clock enable drops. A scan of the selected counter captures its present value, so software can read back how far the test has run. Entry to Test-Logic-Reset clears the counter and switches it off.

Top module: `bist_tck_counter`

## Requirements
- R1: After asynchronous reset the count is 0, the counter is off, term_o is 1, lclk_en_o is 1 and tdo_o is 0.
- R2: An update_dr_i edge while cnt_sel_i is high loads the shift register into the count. The count is CNT_W bits, shifted in LSB first through tdi_i.
- R3: While the counter is on, the count drops by one on every test-clock edge after the loading edge. For a loaded value N>0, term_o is 0 for N-1 edges after the loading edge and is 1 from edge N.
- R4: At zero the count holds at zero and does not wrap, even while the counter is on.
- R5: cnt_on_i switches counting on and cnt_off_i switches it off, with off winning if both are high. While off, the count holds.
- R6: A loaded value of zero gives term_o = 1 immediately after the loading edge.
- R7: lclk_en_o is 0 exactly when the counter is on, the count is 0 and parked_i is 1. Otherwise it is 1.
- R8: An edge with tlr_i high clears the count to 0 and switches the counter off, taking priority over every other input.
- R9: A capture_dr_i edge with cnt_sel_i high copies the count, as it stood before that edge, into the shift register. Each shift_dr_i edge then moves it one place toward tdo_o, LSB first.
- R10: With cnt_sel_i low, capture, shift and update strobes leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tlr_i | input | 1 | TAP is in Test-Logic-Reset |
| capture_dr_i | input | 1 | TAP is in Capture-DR |
| shift_dr_i | input | 1 | TAP is in Shift-DR |
| update_dr_i | input | 1 | TAP is in Update-DR |
| cnt_sel_i | input | 1 | Counter is the selected data register |
| cnt_on_i | input | 1 | Counter-on command strobe |
| cnt_off_i | input | 1 | Counter-off command strobe |
| tdi_i | input | 1 | Scan data in |
| parked_i | input | 1 | Local port is parked |
| tdo_o | output | 1 | Scan data out |
| term_o | output | 1 | Terminal count reached (mode register bit 7) |
| lclk_en_o | output | 1 | Local test clock enable, 0 = gated |

## Verification
A count that loses or gains a step shows up at once on term_o, which then rises one edge early or late against the loaded value. Such a count also appears in any later readback scan, 33 edges after its capture. A stuck on-flag or parked term bit shows directly on lclk_en_o in the same cycle, and a count that wraps leaves zero on the next edge. Readbacks taken with the counter off expose a count that drifts while it should hold.

// File: rtl/bist_cnt_pkg.sv
package bist_cnt_pkg;
  localparam int unsigned CNT_W_DEF = 32;

  typedef enum logic [1:0] {
    DR_IDLE  = 2'd0,
    DR_CAPT  = 2'd1,
    DR_SHIFT = 2'd2,
    DR_UPD   = 2'd3
  } dr_op_e;
endpackage

// File: rtl/bist_dr_shift.sv
module bist_dr_shift
  import bist_cnt_pkg::*;
#(
  parameter int unsigned W = CNT_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  dr_op_e       op_i,
  input  logic         tdi_i,
  input  logic [W-1:0] par_i,
  output logic [W-1:0] q_o,
  output logic         tdo_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '0;
    else if (clr_i) sr_q <= '0;
    else begin
      case (op_i)
        DR_CAPT:  sr_q <= par_i;
        DR_SHIFT: sr_q <= {tdi_i, sr_q[W-1:1]};
        default:  sr_q <= sr_q;
      endcase
    end
  end

  assign q_o   = sr_q;
  assign tdo_o = sr_q[0];
endmodule

// File: rtl/bist_down_cnt.sv
module bist_down_cnt
  import bist_cnt_pkg::*;
#(
  parameter int unsigned W = CNT_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         on_cmd_i,
  input  logic         off_cmd_i,
  output logic [W-1:0] cnt_o,
  output logic         on_o,
  output logic         term_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic         on_q;
  logic         zero;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        on_q <= 1'b0;
    else if (clr_i)     on_q <= 1'b0;
    else if (off_cmd_i) on_q <= 1'b0;
    else if (on_cmd_i)  on_q <= 1'b1;
  end

  // load edge does not count; saturate at zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (on_q && !zero)   cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign on_o   = on_q;
  assign term_o = zero;
endmodule

// File: rtl/bist_clk_gate_ctl.sv
module bist_clk_gate_ctl (
  input  logic on_i,
  input  logic term_i,
  input  logic parked_i,
  output logic en_o
);
  assign en_o = ~(on_i & term_i & parked_i);
endmodule

// File: rtl/bist_tck_counter.sv
module bist_tck_counter
  import bist_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tlr_i,
  input  logic capture_dr_i,
  input  logic shift_dr_i,
  input  logic update_dr_i,
  input  logic cnt_sel_i,
  input  logic cnt_on_i,
  input  logic cnt_off_i,
  input  logic tdi_i,
  input  logic parked_i,
  output logic tdo_o,
  output logic term_o,
  output logic lclk_en_o
);
  dr_op_e           dr_op;
  logic [CNT_W-1:0] sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             on_q;
  logic             term_w;
  logic             load_w;

  always_comb begin
    dr_op = DR_IDLE;
    if (cnt_sel_i) begin
      if (update_dr_i)       dr_op = DR_UPD;
      else if (shift_dr_i)   dr_op = DR_SHIFT;
      else if (capture_dr_i) dr_op = DR_CAPT;
    end
  end

  assign load_w = (dr_op == DR_UPD);

  bist_dr_shift #(.W(CNT_W)) u_shift (
    .clk_i  (tck_i),
    .rst_ni (rst_ni),
    .clr_i  (tlr_i),
    .op_i   (dr_op),
    .tdi_i  (tdi_i),
    .par_i  (cnt_q),
    .q_o    (sr_q),
    .tdo_o  (tdo_o)
  );

  bist_down_cnt #(.W(CNT_W)) u_cnt (
    .clk_i      (tck_i),
    .rst_ni     (rst_ni),
    .clr_i      (tlr_i),
    .load_i     (load_w),
    .load_val_i (sr_q),
    .on_cmd_i   (cnt_on_i),
    .off_cmd_i  (cnt_off_i),
    .cnt_o      (cnt_q),
    .on_o       (on_q),
    .term_o     (term_w)
  );

  bist_clk_gate_ctl u_gate (
    .on_i     (on_q),
    .term_i   (term_w),
    .parked_i (parked_i),
    .en_o     (lclk_en_o)
  );

  assign term_o = term_w;
endmodule

// File: rtl/bist_tck_counter_chk.sv
module bist_tck_counter_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             tck_i,
  input logic             rst_ni,
  input logic             tlr_i,
  input logic             parked_i,
  input logic             term_o,
  input logic             lclk_en_o,
  input logic             load_w,
  input logic             on_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] sr_q
);
  p_load_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (load_w && !tlr_i) |=> (cnt_q == $past(sr_q)));

  p_step_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (on_q && !tlr_i && !load_w && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_no_wrap_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (term_o && !load_w) |=> term_o);

  p_off_hold_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!on_q && !tlr_i && !load_w) |=> $stable(cnt_q));

  p_gate_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !lclk_en_o |-> (parked_i && term_o));

  p_tlr_clear_r8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |=> (term_o && lclk_en_o));
endmodule

bind bist_tck_counter bist_tck_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .tck_i     (tck_i),
  .rst_ni    (rst_ni),
  .tlr_i     (tlr_i),
  .parked_i  (parked_i),
  .term_o    (term_o),
  .lclk_en_o (lclk_en_o),
  .load_w    (load_w),
  .on_q      (on_q),
  .cnt_q     (cnt_q),
  .sr_q      (sr_q)
);

// File: tb/bist_tck_counter_bench.sv
module bist_tck_counter_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tlr = 0, cap = 0, shf = 0, upd = 0, sel = 0, on_c = 0, off_c = 0, tdi = 0, parked = 0;
  logic tdo, term, en;

  always #5 clk = ~clk;

  bist_tck_counter #(.CNT_W(W)) u_bist_tck_counter (
    .tck_i(clk), .rst_ni(rst_n), .tlr_i(tlr), .capture_dr_i(cap), .shift_dr_i(shf),
    .update_dr_i(upd), .cnt_sel_i(sel), .cnt_on_i(on_c), .cnt_off_i(off_c),
    .tdi_i(tdi), .parked_i(parked), .tdo_o(tdo), .term_o(term), .lclk_en_o(en)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { string req; logic [W-1:0] val; } exp_t;
  exp_t exp_q[$];
  logic [W-1:0] rd_val;
  logic rd_valid = 0;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected readbacks as results appear
  initial begin
    forever begin
      @(posedge clk);
      if (rd_valid) begin
        if (exp_q.size() == 0) chk("queue", rd_val, '1);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.req, rd_val, e.val);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [W-1:0] v, bit use_sel = 1);
    sel = use_sel; shf = 1;
    for (int i = 0; i < W; i++) begin tdi = v[i]; @(negedge clk); end
    shf = 0; upd = 1; @(negedge clk);
    upd = 0; sel = 0; tdi = 0;
  endtask

  task automatic read(string req, logic [W-1:0] exp);
    logic [W-1:0] r;
    exp_t e;
    e.req = req; e.val = exp; exp_q.push_back(e);
    sel = 1; cap = 1; @(negedge clk);
    cap = 0; shf = 1;
    for (int i = 0; i < W; i++) begin r[i] = tdo; @(negedge clk); end
    shf = 0; sel = 0;
    rd_val = r; rd_valid = 1; @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic cmd_on();  on_c = 1;  @(negedge clk); on_c = 0;  endtask
  task automatic cmd_off(); off_c = 1; @(negedge clk); off_c = 0; endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    chk("R1 term", term, 1);
    chk("R1 en", en, 1);
    chk("R1 tdo", tdo, 0);
    rst_n = 1;
    tick(1);

    // R2 load and readback, counter off
    load(32'hA5C3_1E77);
    read("R2 load", 32'hA5C3_1E77);
    read("R5 hold while off", 32'hA5C3_1E77);

    // R10 strobes without select
    load(32'hFFFF_FFFF, 0);
    read("R10 unselected", 32'hA5C3_1E77);

    // R3 countdown timing
    cmd_on();
    load(5);
    chk("R3 k0", term, 0);
    tick(4);
    chk("R3 k4", term, 0);
    tick(1);
    chk("R3 k5", term, 1);
    tick(3);
    chk("R4 hold zero", term, 1);
    cmd_off();
    read("R4 no wrap", 0);

    // R5 on/off control
    cmd_on();
    load(100);
    tick(10);
    cmd_off();
    tick(20);
    read("R5 off hold", 89);
    on_c = 1; off_c = 1; @(negedge clk); on_c = 0; off_c = 0;
    tick(5);
    read("R5 off wins", 89);

    // R6 zero load, R7 gating
    cmd_on();
    load(0);
    chk("R6 zero term", term, 1);
    parked = 1; #1;
    chk("R7 gated", en, 0);
    parked = 0; #1;
    chk("R7 not parked", en, 1);
    parked = 1;
    cmd_off();
    chk("R7 off", en, 1);
    cmd_on();
    chk("R7 on again", en, 0);
    load(3);
    chk("R7 not term", en, 1);
    tick(3);
    chk("R7 term gated", en, 0);

    // R8 test-logic-reset
    load(50);
    tick(2);
    tlr = 1; @(negedge clk); tlr = 0;
    chk("R8 term", term, 1);
    chk("R8 en", en, 1);
    read("R8 cleared", 0);
    load(7);
    tick(10);
    read("R8 off after reset", 7);
    parked = 0;

    // R9 capture during counting
    cmd_on();
    load(40);
    tick(5);
    read("R9 capture live", 35);

    tick(3);
    chk("queue drained", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule